// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block turns the input pins of three 8-bit ports into interrupt requests. The ports are called A, B and F. Each pin is first passed through a two-flop synchronizer. A per-pin debounce filter can optionally follow the synchronizer. Detection then runs in one of two modes, chosen per pin:

- **Level mode:** a pin requests service while its filtered level equals a chosen polarity.
- **Edge mode:** a pin latches a pending flag when a chosen transition occurs, and the flag stays set until software acknowledges it.

Ports A and B share one interrupt output. Each bit of port F has its own output.

Software controls the block through a byte-wide register bus with one write strobe and a combinational read. Every port has six registers: trigger kind, polarity, enable, acknowledge (write only), debounce select and masked status. Software emulates both-edge interrupts by inverting a pin's polarity after each acknowledge. For that reason, a polarity write applies to the very next sample comparison.

The register offsets are fixed per port. Each port's base is its trigger-kind offset: A = 0x90, B = 0xAC, F = 0x4C. The other registers sit at fixed distances from that base:

| Register | Offset from base |
|---|---|
| polarity | +0x04 |
| acknowledge | +0x08 |
| enable | +0x0C |
| status | +0x10 |
| debounce | +0x18 |

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register reads 0, no edge is pending, and `irq_ab` and `irq_f` are 0.
- R2: Kind, polarity, enable and debounce registers read back what was last written at their offsets. A write to one port leaves the other ports unchanged.
- R3: Level mode (kind bit 0) applies when a pin's polarity bit is 1 (high) or 0 (low). In that mode the status bit is set while the enabled pin's sampled level equals the polarity bit. It clears by itself when the level changes, with no acknowledge needed.
- R4: Edge mode (kind bit 1) latches a pending flag. Polarity 1 selects a rising edge and polarity 0 a falling edge. The flag stays set after the pin returns, and the opposite transition sets nothing.
- R5: Writing the acknowledge register clears the pending flag of each bit written as 1. Bits written as 0 keep their flag.
- R6: Status and interrupt outputs show only enabled bits. An edge latched while its bit is disabled appears once the bit is enabled.
- R7: `irq_ab` is the OR of the status bits of ports A and B. Bit i of `irq_f` is status bit i of port F.
- R8: A pin with its debounce bit set changes its filtered level only after the synchronized input has differed from the filtered level on 4 consecutive `tick` cycles. Shorter pulses are ignored, and without `tick` the filtered level never changes.
- R9: A polarity change applies to edge detection from the next sample on.
- R10: If an edge arrives in the same cycle as an acknowledge of that bit, the flag stays set.
- R11: A pin change reaches level status 2 clocks after it is sampled and sets an edge flag 3 clocks after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tick | input | 1 | debounce sample enable |
| we | input | 1 | register write strobe |
| addr | input | 8 | register byte offset |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data for `addr` |
| pin_a | input | 8 | port A pins |
| pin_b | input | 8 | port B pins |
| pin_f | input | 8 | port F pins |
| irq_ab | output | 1 | combined interrupt for ports A and B |
| irq_f | output | 8 | per-pin interrupts for port F |

## Verification
The hardest case to reach is an acknowledge and a new edge landing in the same clock. The bench counts the synchronizer stages: it changes a pin on a falling clock edge and waits two rising edges. It then holds the acknowledge write across the third rising edge, which is exactly when the flag would otherwise set.

The debounce filter is the other difficult case. It is driven with pulses one tick shorter than the threshold and with `tick` held low. The final sample of each checked window falls on the cycle where a counter that was off by one would change the output.

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W        = 8,
  parameter int DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         we,
  input  logic [7:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pin_a,
  input  logic [W-1:0] pin_b,
  input  logic [W-1:0] pin_f,
  output logic         irq_ab,
  output logic [W-1:0] irq_f
);
  localparam int NP = 3;
  localparam int CW = (DB_TICKS > 2) ? $clog2(DB_TICKS) : 1;
  localparam logic [7:0] BASE [NP] = '{8'h90, 8'hAC, 8'h4C};
  localparam logic [7:0] O_POL = 8'h04, O_ACK = 8'h08, O_EN = 8'h0C,
                         O_STAT = 8'h10, O_DEB = 8'h18;

  logic [NP-1:0][W-1:0] kind, pol, en, deb, pend;
  logic [NP-1:0][W-1:0] s1, s2, filt, prev;
  logic [NP-1:0][W-1:0] sel, evt, ack, stat;
  logic [NP-1:0][W-1:0][CW-1:0] cnt;
  logic [NP-1:0][W-1:0] pins;

  assign pins = {pin_f, pin_b, pin_a};

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      sel[p]  = (deb[p] & filt[p]) | (~deb[p] & s2[p]);
      evt[p]  = kind[p] & ((pol[p] & sel[p] & ~prev[p]) | (~pol[p] & ~sel[p] & prev[p]));
      ack[p]  = (we && addr == BASE[p] + O_ACK) ? wdata : '0;
      stat[p] = en[p] & ((kind[p] & pend[p]) | (~kind[p] & ~(sel[p] ^ pol[p])));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind <= '0; pol <= '0; en <= '0; deb <= '0; pend <= '0;
      s1 <= '0; s2 <= '0; filt <= '0; prev <= '0; cnt <= '0;
    end else begin
      s1   <= pins;
      s2   <= s1;
      prev <= sel;
      pend <= (pend & ~ack) | evt;
      for (int p = 0; p < NP; p++) begin
        for (int b = 0; b < W; b++) begin
          if (tick) begin
            if (s2[p][b] != filt[p][b]) begin
              if (cnt[p][b] == CW'(DB_TICKS - 1)) begin
                filt[p][b] <= s2[p][b];
                cnt[p][b]  <= '0;
              end else begin
                cnt[p][b] <= cnt[p][b] + 1'b1;
              end
            end else begin
              cnt[p][b] <= '0;
            end
          end
        end
        if (we) begin
          if (addr == BASE[p])         kind[p] <= wdata;
          if (addr == BASE[p] + O_POL) pol[p]  <= wdata;
          if (addr == BASE[p] + O_EN)  en[p]   <= wdata;
          if (addr == BASE[p] + O_DEB) deb[p]  <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NP; p++) begin
      if (addr == BASE[p])          rdata = kind[p];
      if (addr == BASE[p] + O_POL)  rdata = pol[p];
      if (addr == BASE[p] + O_EN)   rdata = en[p];
      if (addr == BASE[p] + O_DEB)  rdata = deb[p];
      if (addr == BASE[p] + O_STAT) rdata = stat[p];
    end
  end

  assign irq_ab = |{stat[1], stat[0]};
  assign irq_f  = stat[2];
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           we,
  input logic [7:0]     addr,
  input logic [W-1:0]   wdata,
  input logic           irq_ab,
  input logic [W-1:0]   irq_f,
  input logic [3*W-1:0] en,
  input logic [3*W-1:0] pend,
  input logic [3*W-1:0] evt
);
  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (irq_ab == 1'b0 && irq_f == '0);

  assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h54) |=> ((pend[3*W-1:2*W] & $past(wdata & ~evt[3*W-1:2*W])) == '0));

  assert_enable_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_f & ~en[3*W-1:2*W]) == '0));

  assert_ab_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ab |-> (en[2*W-1:0] != '0));

  assert_race_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 8'h54 && (wdata & evt[3*W-1:2*W]) != '0)
      |=> ((pend[3*W-1:2*W] & $past(wdata & evt[3*W-1:2*W])) == $past(wdata & evt[3*W-1:2*W])));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .irq_ab(irq_ab), .irq_f(irq_f), .en(en), .pend(pend), .evt(evt)
);

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
  logic clk = 0, rst_n = 0, tick = 1, we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [7:0] pin_a = 0, pin_b = 0, pin_f = 0, irq_f;
  logic irq_ab;
  int runs = 0, fails = 0;
  bit done = 0;

  localparam logic [7:0] A = 8'h90, B = 8'hAC, F = 8'h4C;
  localparam logic [7:0] POL = 8'h04, ACK = 8'h08, EN = 8'h0C, ST = 8'h10, DEB = 8'h18;

  gpio_irq_unit uut (.clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .pin_f(pin_f),
    .irq_ab(irq_ab), .irq_f(irq_f));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int p = 0; p < 3; p++) begin
      logic [7:0] base = (p == 0) ? A : (p == 1) ? B : F;
      rd(base, d);        chk("R1 kind", d, 0);
      rd(base + POL, d);  chk("R1 pol", d, 0);
      rd(base + EN, d);   chk("R1 en", d, 0);
      rd(base + DEB, d);  chk("R1 deb", d, 0);
      rd(base + ST, d);   chk("R1 stat", d, 0);
    end
    chk("R1 irq_ab", {7'd0, irq_ab}, 0);
    chk("R1 irq_f", irq_f, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d;
    wr(A, 8'hA5); wr(A + POL, 8'h3C); wr(B + DEB, 8'h81); wr(F + EN, 8'h00); wr(F, 8'h5A);
    rd(A, d);       chk("R2 kind A", d, 8'hA5);
    rd(A + POL, d); chk("R2 pol A", d, 8'h3C);
    rd(B + DEB, d); chk("R2 deb B", d, 8'h81);
    rd(F, d);       chk("R2 kind F", d, 8'h5A);
    rd(B, d);       chk("R2 kind B untouched", d, 8'h00);
    wr(A, 0); wr(A + POL, 0); wr(B + DEB, 0); wr(F, 0);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(A + POL, 8'h01); wr(A + EN, 8'h01);
    chk("R3 idle", {7'd0, irq_ab}, 0);
    @(negedge clk); pin_a[0] = 1;
    edges(1); chk("R11 level latency 1", {7'd0, irq_ab}, 0);
    edges(1); chk("R11 level latency 2", {7'd0, irq_ab}, 1);
    rd(A + ST, d); chk("R3 status high", d, 8'h01);
    @(negedge clk); pin_a[0] = 0;
    edges(2); chk("R3 self clears", {7'd0, irq_ab}, 0);
    wr(A + EN, 0); wr(A + POL, 0);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wr(B, 8'hFF); wr(B + POL, 8'h0F); wr(B + EN, 8'hFF);
    @(negedge clk); pin_b = 8'h13;
    edges(2); rd(B + ST, d); chk("R11 edge latency 2", d, 8'h00);
    edges(1); rd(B + ST, d); chk("R4 rising latched", d, 8'h03);
    @(negedge clk); pin_b = 8'h00;
    edges(3); rd(B + ST, d); chk("R4 falling latched, held", d, 8'h13);
    wr(B + ACK, 8'h01); rd(B + ST, d); chk("R5 ack partial", d, 8'h12);
    chk("R7 irq_ab from B", {7'd0, irq_ab}, 1);
    wr(B + ACK, 8'h12); rd(B + ST, d); chk("R5 ack rest", d, 8'h00);
    chk("R7 irq_ab clear", {7'd0, irq_ab}, 0);
    wr(B + EN, 0); wr(B, 0); wr(B + POL, 0);
  endtask

  task automatic t_enable;
    logic [7:0] d;
    wr(F, 8'hFF); wr(F + POL, 8'hFF);
    @(negedge clk); pin_f[2] = 1;
    edges(4); chk("R6 disabled irq_f", irq_f, 0);
    rd(F + ST, d); chk("R6 disabled status", d, 0);
    wr(F + EN, 8'hFF); chk("R6 held edge shows", irq_f, 8'h04);
    chk("R7 irq_ab not from F", {7'd0, irq_ab}, 0);
    wr(F + ACK, 8'h04); chk("R5 F ack", irq_f, 0);
  endtask

  task automatic t_portf;
    @(negedge clk); pin_f[5] = 1;
    edges(3); chk("R7 per-pin irq_f", irq_f, 8'h20);
    wr(A, 8'h01); wr(A + POL, 8'h01); wr(A + EN, 8'h01);
    @(negedge clk); pin_a[0] = 1;
    edges(3); chk("R7 irq_ab from A", {7'd0, irq_ab}, 1);
    chk("R7 irq_f unchanged", irq_f, 8'h20);
    wr(A + ACK, 8'h01); wr(F + ACK, 8'h20);
    chk("R7 both clear", {irq_f[6:0], irq_ab}, 0);
  endtask

  task automatic t_polflip;
    wr(F + POL, 8'hDF);
    @(negedge clk); pin_f[5] = 0;
    edges(3); chk("R9 falling after flip", irq_f, 8'h20);
    wr(F + POL, 8'hFF); wr(F + ACK, 8'h20);
    @(negedge clk); pin_f[5] = 1;
    edges(3); chk("R9 rising after flip back", irq_f, 8'h20);
    wr(F + ACK, 8'h20); wr(F + EN, 0);
  endtask

  task automatic t_debounce;
    wr(A, 0); wr(A + POL, 8'h80); wr(A + DEB, 8'h80); wr(A + EN, 8'h80);
    @(negedge clk); pin_a[7] = 1;
    repeat (3) @(negedge clk); pin_a[7] = 0;
    edges(10); chk("R8 short pulse ignored", {7'd0, irq_ab}, 0);
    @(negedge clk); pin_a[7] = 1;
    edges(5); chk("R8 not yet at 3 ticks", {7'd0, irq_ab}, 0);
    edges(1); chk("R8 changes at 4 ticks", {7'd0, irq_ab}, 1);
    @(negedge clk); tick = 0; pin_a[7] = 0;
    edges(20); chk("R8 no tick no change", {7'd0, irq_ab}, 1);
    @(negedge clk); tick = 1;
    edges(6); chk("R8 filtered low", {7'd0, irq_ab}, 0);
    wr(A + EN, 0); wr(A + DEB, 0); wr(A + POL, 0);
  endtask

  task automatic t_race;
    logic [7:0] d;
    wr(A, 8'h04); wr(A + POL, 8'h04); wr(A + EN, 8'h04);
    @(negedge clk); pin_a[2] = 1;
    @(posedge clk); @(posedge clk);
    wr(A + ACK, 8'h04);
    rd(A + ST, d); chk("R10 edge beats ack", d, 8'h04);
    wr(A + ACK, 8'h04);
    rd(A + ST, d); chk("R5 later ack clears", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset; t_regs; t_level; t_edge; t_enable; t_portf; t_polflip; t_debounce; t_race;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule